// File: doc/BRIEF.md
# CAN Controller Status Word and Interrupt Line

This block keeps the status word of a CAN controller and drives its single interrupt line. The protocol engine delivers one-cycle event pulses (wake-up seen while powered down, parity fault, frame received, frame sent and a new last-error code) and three level signals that describe the current error state (bus-off, warning limit reached, error passive). Pulsed events are caught in sticky flags. The levels are mirrored one cycle late. A small register port lets the CPU read the status word and read or write a three-bit control word that holds the interrupt enables.

Reading the status word has side effects. The read clears the four sticky flags and the status-change pending state, and it forces the last-error code to all ones. These take effect on the clock edge that closes the read cycle. If an event arrives in that same cycle, the event wins. Interrupt causes come in two groups, error and status-change, and each group has its own enable. A master line enable gates the output.

Top module: `can_stat_irq`

## Requirements
- R1: With `cpu_addr`=1, `cpu_rdata` shows the status word: last-error code in bits 2:0, sent-OK flag in bit 3, received-OK flag in bit 4, error-passive mirror in bit 5, warning mirror in bit 6, bus-off mirror in bit 7, parity flag in bit 8, wake-up flag in bit 9, and zero in bits 31:10. With `cpu_addr`=0 it shows the control word in bits 2:0 and zero above. `cpu_rdata` is combinational from `cpu_addr` and the register state.
- R2: After a synchronous reset, the last-error code is 3'b111, every flag and mirror is 0, the control word is 0 and `irq` is 0.
- R3: A pulse on `ev_wake`, `ev_parity`, `ev_rx_ok` or `ev_tx_ok` sets its flag at the next edge, and the flag holds until a status read.
- R4: A status read (`cpu_rd`=1 with `cpu_addr`=1) clears the wake-up, parity, received-OK and sent-OK flags and sets the last-error code to 3'b111 at the edge that closes the read cycle.
- R5: When an event and a clearing status read hit the same flag or code in the same cycle, the event's value is kept.
- R6: The bus-off, warning and error-passive fields equal `lvl_boff`, `lvl_ewarn` and `lvl_epass` of the previous cycle, and a status read does not change them.
- R7: When `ev_lec_vld`=1, the last-error code takes the value of `ev_lec` at the next edge.
- R8: `cpu_wr` with `cpu_addr`=0 loads `cpu_wdata[2:0]` into the control word. Bit 0 is the line enable, bit 1 the status-change enable and bit 2 the error enable. A write with `cpu_addr`=1 has no effect.
- R9: While the line enable is 0, `irq` is 0.
- R10: With the error enable set, a set parity flag, bus-off mirror or warning mirror raises `irq`. The error-passive mirror is never a cause. With the error enable clear, error causes have no effect.
- R11: With the status-change enable set, a set wake-up, received-OK or sent-OK flag, or a last-error code update since the last status read, raises `irq` until a status read clears it.
- R12: `irq` is the OR of the two enabled groups, gated by the line enable. It falls once every enabled cause has been serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_wake | input | 1 | Dominant bus seen while powered down (pulse) |
| ev_parity | input | 1 | Parity fault (pulse) |
| ev_rx_ok | input | 1 | Frame received without error (pulse) |
| ev_tx_ok | input | 1 | Frame sent without error (pulse) |
| ev_lec_vld | input | 1 | New last-error code present on ev_lec |
| ev_lec | input | 3 | Last-error code value |
| lvl_boff | input | 1 | Bus-off state level |
| lvl_ewarn | input | 1 | Error warning level |
| lvl_epass | input | 1 | Error passive level |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_addr | input | 1 | 0 = control word, 1 = status word |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data for cpu_addr |
| irq | output | 1 | Interrupt line |

## Verification
The bench goes after the cycle where a clearing read and a new event meet. A design that let the read win would lose a flag or a code, and the bench would see the flag missing on the next read. It also checks that a read leaves the error mirrors untouched, since a design that cleared them would report a bus that looks healthy. Other targets are error-passive acting as an interrupt cause, a write to the status address changing the enables, and a status-change interrupt from a code update that never drops or that survives the read. Random traffic then mixes all of these against a model built from the requirements.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

    localparam int DATA_W   = 32;
    localparam int LEC_W    = 3;
    localparam int N_STICKY = 4;
    localparam int CTL_W    = 3;

    // sticky flag indices
    localparam int STK_TX   = 0;
    localparam int STK_RX   = 1;
    localparam int STK_PAR  = 2;
    localparam int STK_WAKE = 3;

    typedef struct packed {
        logic err_en;
        logic stat_en;
        logic line_en;
    } ctl_t;

    typedef struct packed {
        logic boff;
        logic ewarn;
        logic epass;
    } errlvl_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [N_STICKY-1:0] stk,
        input errlvl_t             lvl,
        input logic [LEC_W-1:0]    lec
    );
        logic [DATA_W-1:0] w;
        w        = '0;
        w[2:0]   = lec;
        w[3]     = stk[STK_TX];
        w[4]     = stk[STK_RX];
        w[5]     = lvl.epass;
        w[6]     = lvl.ewarn;
        w[7]     = lvl.boff;
        w[8]     = stk[STK_PAR];
        w[9]     = stk[STK_WAKE];
        return w;
    endfunction

endpackage

// File: rtl/can_stat_flags.sv
module can_stat_flags
    import can_stat_pkg::*;
#(
    parameter int NSTK = N_STICKY,
    parameter int LW   = LEC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSTK-1:0] ev_stk,
    input  logic            rd_clr,
    input  logic            lec_vld,
    input  logic [LW-1:0]   lec_in,
    input  errlvl_t         lvl_in,
    output logic [NSTK-1:0] stk_q,
    output logic [LW-1:0]   lec_q,
    output logic            lec_upd_q,
    output errlvl_t         lvl_q
);

    localparam logic [LW-1:0] LEC_IDLE = {LW{1'b1}};

    for (genvar i = 0; i < NSTK; i++) begin : g_stk
        always_ff @(posedge clk) begin
            if (rst)            stk_q[i] <= 1'b0;
            else if (ev_stk[i]) stk_q[i] <= 1'b1;
            else if (rd_clr)    stk_q[i] <= 1'b0;
        end

        p_set_hold_r3: assert property (@(posedge clk) disable iff (rst)
            ev_stk[i] |=> stk_q[i]);
        p_read_clear_r4: assert property (@(posedge clk) disable iff (rst)
            (rd_clr && !ev_stk[i]) |=> !stk_q[i]);
        p_quiet_hold_r3: assert property (@(posedge clk) disable iff (rst)
            (!rd_clr && !ev_stk[i]) |=> $stable(stk_q[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lec_q     <= LEC_IDLE;
            lec_upd_q <= 1'b0;
            lvl_q     <= '0;
        end else begin
            lvl_q <= lvl_in;
            if (lec_vld)     lec_q <= lec_in;
            else if (rd_clr) lec_q <= LEC_IDLE;
            if (lec_vld)     lec_upd_q <= 1'b1;
            else if (rd_clr) lec_upd_q <= 1'b0;
        end
    end

    p_lec_load_r7: assert property (@(posedge clk) disable iff (rst)
        lec_vld |=> (lec_q == $past(lec_in)));
    p_lec_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !lec_vld) |=> (lec_q == LEC_IDLE));
    p_mirror_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lvl_q == $past(lvl_in)));

endmodule

// File: rtl/can_stat_irqgen.sv
module can_stat_irqgen
    import can_stat_pkg::*;
#(
    parameter int NSTK = N_STICKY
) (
    input  ctl_t            ctl,
    input  logic [NSTK-1:0] stk_q,
    input  logic            lec_upd_q,
    input  errlvl_t         lvl_q,
    output logic            irq
);

    logic err_cause;
    logic stat_cause;

    always_comb begin
        err_cause  = stk_q[STK_PAR] | lvl_q.boff | lvl_q.ewarn;
        stat_cause = stk_q[STK_WAKE] | stk_q[STK_RX] | stk_q[STK_TX] | lec_upd_q;
        irq = ctl.line_en & ((ctl.err_en & err_cause) | (ctl.stat_en & stat_cause));
    end

endmodule

// File: rtl/can_stat_irq.sv
module can_stat_irq
    import can_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_wake,
    input  logic              ev_parity,
    input  logic              ev_rx_ok,
    input  logic              ev_tx_ok,
    input  logic              ev_lec_vld,
    input  logic [LEC_W-1:0]  ev_lec,
    input  logic              lvl_boff,
    input  logic              lvl_ewarn,
    input  logic              lvl_epass,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic              cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              irq
);

    ctl_t                ctl_q;
    logic [N_STICKY-1:0] ev_stk;
    logic [N_STICKY-1:0] stk_q;
    logic [LEC_W-1:0]    lec_q;
    logic                lec_upd_q;
    errlvl_t             lvl_in;
    errlvl_t             lvl_q;
    logic                rd_stat;
    logic                wr_ctl;
    logic                unused_wdata;

    assign unused_wdata = ^cpu_wdata[DATA_W-1:CTL_W];

    always_comb begin
        rd_stat          = cpu_rd & cpu_addr;
        wr_ctl           = cpu_wr & ~cpu_addr;
        ev_stk           = '0;
        ev_stk[STK_TX]   = ev_tx_ok;
        ev_stk[STK_RX]   = ev_rx_ok;
        ev_stk[STK_PAR]  = ev_parity;
        ev_stk[STK_WAKE] = ev_wake;
        lvl_in.boff      = lvl_boff;
        lvl_in.ewarn     = lvl_ewarn;
        lvl_in.epass     = lvl_epass;
    end

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (wr_ctl) ctl_q <= ctl_t'(cpu_wdata[CTL_W-1:0]);
    end

    can_stat_flags #(.NSTK(N_STICKY), .LW(LEC_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .ev_stk    (ev_stk),
        .rd_clr    (rd_stat),
        .lec_vld   (ev_lec_vld),
        .lec_in    (ev_lec),
        .lvl_in    (lvl_in),
        .stk_q     (stk_q),
        .lec_q     (lec_q),
        .lec_upd_q (lec_upd_q),
        .lvl_q     (lvl_q)
    );

    can_stat_irqgen #(.NSTK(N_STICKY)) u_irq (
        .ctl       (ctl_q),
        .stk_q     (stk_q),
        .lec_upd_q (lec_upd_q),
        .lvl_q     (lvl_q),
        .irq       (irq)
    );

    always_comb begin
        if (cpu_addr) cpu_rdata = pack_status(stk_q, lvl_q, lec_q);
        else          cpu_rdata = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
    end

    p_line_off_r9: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.line_en |-> !irq);
    p_err_raise_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.line_en && ctl_q.err_en && (lvl_q.boff || lvl_q.ewarn || stk_q[STK_PAR])) |-> irq);
    p_stat_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !ctl_q.err_en && !wr_ctl && !ev_wake && !ev_parity && !ev_rx_ok
         && !ev_tx_ok && !ev_lec_vld) |=> !irq);
    p_wr_status_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr) |=> $stable(ctl_q));

endmodule

// File: tb/tb_can_stat_irq.sv
module tb_can_stat_irq;

    logic        clk = 1'b0;
    logic        rst;
    logic        ev_wake, ev_parity, ev_rx_ok, ev_tx_ok, ev_lec_vld;
    logic [2:0]  ev_lec;
    logic        lvl_boff, lvl_ewarn, lvl_epass;
    logic        cpu_rd, cpu_wr, cpu_addr;
    logic [31:0] cpu_wdata;
    logic [31:0] cpu_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic m_wake, m_par, m_rx, m_tx, m_lupd;
    logic m_boff, m_ewarn, m_epass;
    logic [2:0] m_lec;
    logic [2:0] m_ctl;

    always #5 clk = ~clk;

    can_stat_irq dut (
        .clk(clk), .rst(rst),
        .ev_wake(ev_wake), .ev_parity(ev_parity), .ev_rx_ok(ev_rx_ok), .ev_tx_ok(ev_tx_ok),
        .ev_lec_vld(ev_lec_vld), .ev_lec(ev_lec),
        .lvl_boff(lvl_boff), .lvl_ewarn(lvl_ewarn), .lvl_epass(lvl_epass),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_rdata(input logic a);
        logic [31:0] w;
        w = '0;
        if (a) begin
            w[2:0] = m_lec; w[3] = m_tx; w[4] = m_rx; w[5] = m_epass;
            w[6] = m_ewarn; w[7] = m_boff; w[8] = m_par; w[9] = m_wake;
        end else begin
            w[2:0] = m_ctl;
        end
        return w;
    endfunction

    function automatic logic exp_irq();
        logic e, s;
        e = m_par | m_boff | m_ewarn;
        s = m_wake | m_rx | m_tx | m_lupd;
        return m_ctl[0] & ((m_ctl[2] & e) | (m_ctl[1] & s));
    endfunction

    task automatic model_reset();
        m_wake = 0; m_par = 0; m_rx = 0; m_tx = 0; m_lupd = 0;
        m_boff = 0; m_ewarn = 0; m_epass = 0; m_lec = 3'b111; m_ctl = 3'b000;
    endtask

    task automatic model_edge();
        logic rs;
        rs = cpu_rd & cpu_addr;
        m_wake = ev_wake   | (m_wake & ~rs);
        m_par  = ev_parity | (m_par  & ~rs);
        m_rx   = ev_rx_ok  | (m_rx   & ~rs);
        m_tx   = ev_tx_ok  | (m_tx   & ~rs);
        m_lupd = ev_lec_vld | (m_lupd & ~rs);
        if (ev_lec_vld) m_lec = ev_lec;
        else if (rs)    m_lec = 3'b111;
        m_boff = lvl_boff; m_ewarn = lvl_ewarn; m_epass = lvl_epass;
        if (cpu_wr && !cpu_addr) m_ctl = cpu_wdata[2:0];
    endtask

    task automatic clr_pulses();
        ev_wake = 0; ev_parity = 0; ev_rx_ok = 0; ev_tx_ok = 0; ev_lec_vld = 0;
        ev_lec = 3'b000; cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0;
    endtask

    // called just after a falling edge with inputs set; checks, then advances one cycle
    task automatic cyc(input string tag);
        logic [31:0] er;
        logic        ei;
        #1;
        er = exp_rdata(cpu_addr);
        ei = exp_irq();
        n_chk++;
        if (cpu_rdata !== er) begin
            n_bad++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, cpu_addr, cpu_rdata, er);
        end
        n_chk++;
        if (irq !== ei) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, ei);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [2:0] v, input string tag);
        clr_pulses(); cpu_wr = 1; cpu_addr = 0; cpu_wdata = {29'h1ABCDE00 >> 3, v};
        cyc(tag);
        clr_pulses();
    endtask

    task automatic rd_stat(input string tag);
        clr_pulses(); cpu_rd = 1; cpu_addr = 1;
        cyc(tag);
        clr_pulses();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_c0de;
        void'($urandom(seed));
        clr_pulses();
        lvl_boff = 0; lvl_ewarn = 0; lvl_epass = 0; cpu_addr = 1;
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R2: reset state on both addresses
        cpu_addr = 1; cyc("R2");
        cpu_addr = 0; cyc("R2");

        // R3 and R1: sent-OK flag sets and holds at bit 3
        cpu_addr = 1; ev_tx_ok = 1; cyc("R3");
        clr_pulses(); cyc("R1"); cyc("R3");
        ev_wake = 1; ev_parity = 1; cyc("R3");
        clr_pulses(); cyc("R1");

        // R11: status-change enable with line enable
        wr_ctl(3'b011, "R8");
        cpu_addr = 1; cyc("R11");
        // R4: read clears flags, irq drops (R11)
        rd_stat("R4");
        cyc("R11");

        // R5: event with same-cycle read wins
        cpu_addr = 1; cpu_rd = 1; ev_rx_ok = 1; cyc("R5");
        clr_pulses(); cyc("R5");
        rd_stat("R4"); cyc("R4");

        // R7: code load; then read restores 3'b111
        ev_lec_vld = 1; ev_lec = 3'b011; cyc("R7");
        clr_pulses(); cyc("R7"); cyc("R11");
        rd_stat("R4"); cyc("R4");
        // R5: code update in the same cycle as the read
        cpu_rd = 1; ev_lec_vld = 1; ev_lec = 3'b101; cyc("R5");
        clr_pulses(); cyc("R5");
        rd_stat("R4");

        // R6: mirrors follow levels, read leaves them alone
        lvl_boff = 1; lvl_epass = 1; cyc("R6");
        cyc("R6");
        rd_stat("R6"); cyc("R6");

        // R10: error enable only; bus-off raises irq
        wr_ctl(3'b101, "R8");
        cyc("R10");
        lvl_boff = 0; cyc("R10");
        cyc("R10");   // only error-passive: no irq
        lvl_ewarn = 1; cyc("R10");
        cyc("R10");
        wr_ctl(3'b001, "R10");   // error enable clear: warning ignored
        cyc("R10");

        // R9: line enable off with every cause present
        wr_ctl(3'b110, "R9");
        ev_tx_ok = 1; ev_parity = 1; cyc("R9");
        clr_pulses(); cyc("R9");

        // R8: write to status address ignored
        cpu_addr = 1; cpu_wr = 1; cpu_wdata = 32'hFFFF_FFFF; cyc("R8");
        clr_pulses(); cpu_addr = 0; cyc("R8");

        // R12: both groups, drop one group, then the other
        wr_ctl(3'b111, "R12");
        cpu_addr = 1; cyc("R12");
        rd_stat("R12");          // parity and tx cleared, warning level remains
        cyc("R12");
        lvl_ewarn = 0; cyc("R12");
        cyc("R12");

        // random traffic, R3 .. R12 against the model
        for (int i = 0; i < 4000; i++) begin
            clr_pulses();
            ev_wake    = ($urandom_range(0, 19) == 0);
            ev_parity  = ($urandom_range(0, 19) == 0);
            ev_rx_ok   = ($urandom_range(0, 9) == 0);
            ev_tx_ok   = ($urandom_range(0, 9) == 0);
            ev_lec_vld = ($urandom_range(0, 11) == 0);
            ev_lec     = 3'($urandom());
            if ($urandom_range(0, 15) == 0) lvl_boff  = ~lvl_boff;
            if ($urandom_range(0, 15) == 0) lvl_ewarn = ~lvl_ewarn;
            if ($urandom_range(0, 15) == 0) lvl_epass = ~lvl_epass;
            cpu_addr   = ($urandom_range(0, 3) != 0);
            cpu_rd     = ($urandom_range(0, 5) == 0);
            cpu_wr     = ($urandom_range(0, 24) == 0);
            cpu_wdata  = $urandom();
            cyc("R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule